// File: doc/BRIEF.md
# Synchronous Character Serial Transmitter

This block serialises characters for a character-oriented synchronous link. Software or an upstream engine places one byte at a time into a single-entry holding buffer. An internal bit-rate divider paces the line. Each time the character in flight has finished, the block takes the next one with no idle bit period in between. That next character is the buffered byte if one is waiting. Otherwise it is a programmable sync pattern, which keeps the line busy as time fill.

Data characters carry 5 to 8 bits and go out least significant bit first. An optional parity bit follows the data bits. In the shortest length setting, a marker prefix in the written byte trims the character to between one and five data bits. For every bit period that carries a data bit of a character marked for checksumming, the block raises a strobe beside the serial bit. A downstream CRC engine can advance on that strobe. The include mark is taken when the character leaves the buffer, so it can be changed for the next byte as soon as the buffer reports empty.

Top module: `sync_char_tx`

## Requirements
- R1: While reset is held and after it is released until the first bit period, `txd` is 1, `buf_empty` is 1, and `shift_en` and `crc_feed` are 0.
- R2: `shift_en` is a one-cycle pulse that repeats every BAUD_DIV clock cycles, and `txd` changes only in a cycle in which `shift_en` is 1.
- R3: When the buffer is empty at a character boundary, sync fill is sent LSB first. With `cfg_sync16`=1 it is the 16 bits {`sync_hi`,`sync_lo`}, so `sync_lo` bit 0 goes first. Otherwise, with `cfg_sync8`=1 it is the 8 bits of `sync_lo`, and with `cfg_sync8`=0 it is `sync_lo[5:0]`.
- R4: The first bit of each new character, data or sync, is sent in the bit period right after the last bit of the previous one. A waiting data byte always wins over sync fill.
- R5: `cfg_len` selects the data bits per character: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. The low bits of the byte are sent LSB first, and the bits above the length are ignored.
- R6: With `cfg_len`=0, the byte's upper bits set the length. 1111000D sends 1 bit, 111000DD sends 2, 11000DDD sends 3, 1000DDDD sends 4 and 000DDDDD sends 5. Only the D bits are sent.
- R7: With `cfg_par_en`=1, one parity bit follows the data bits of every data character. With `cfg_par_even`=1 the data bits plus the parity bit hold an even number of ones; with 0, an odd number. Sync characters have no parity bit.
- R8: `crc_feed` is 1, together with `shift_en`, exactly in the bit periods of data bits of characters whose include flag was 1. It is never 1 for sync bits or parity bits.
- R9: The include flag of a data character is the value of `cfg_crc_inc` in the cycle the character moves from the buffer into the shifter. Later changes do not affect it.
- R10: `buf_empty` goes to 1 when a data character is moved into the shifter and to 0 on a write. A write to a full buffer replaces the byte. A write in the same cycle as a move leaves the new byte in the buffer and `buf_empty` at 0, while the older byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sync16 | input | 1 | Select 16-bit sync fill |
| cfg_sync8 | input | 1 | When not 16-bit: 1 = 8-bit sync, 0 = 6-bit sync |
| sync_lo | input | 8 | Low sync byte, right-justified, sent first |
| sync_hi | input | 8 | High sync byte, used for 16-bit fill |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Append a parity bit to data characters |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_crc_inc | input | 1 | Include flag for the next character moved out of the buffer |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to place in the holding buffer |
| txd | output | 1 | Serial data |
| shift_en | output | 1 | One-cycle pulse marking a new bit period |
| buf_empty | output | 1 | Holding buffer has no pending byte |
| crc_feed | output | 1 | Current bit is a data bit to be fed to the CRC |

## Verification
The hardest case is a write that lands on the very clock edge where the shifter takes its next character. In that case the older byte must be sent and the new one kept. A second hard case is an include-flag change that arrives after a load but before that character's bits appear. Neither case can be timed from the ports without tracking the bit phase. The stimulus therefore holds the write strobe high for a long stretch with changing data, so that every load edge meets a write. It also toggles the include flag right after the buffer reports empty. Random gaps, lengths, parity and sync settings then cover the remaining phases.

// File: rtl/sct_pkg.sv
// Package: shared sizes, the frame record handed from the framer to the
// shifter, and the rule that maps the length code to a data bit count.
package sct_pkg;

    localparam int SYNC_W    = 8;              // one sync byte
    localparam int DATA_W    = 8;              // holding buffer width
    localparam int SR_W      = 2 * SYNC_W;     // longest character (16-bit sync)
    localparam int CNT_W     = $clog2(SR_W + 1);
    localparam int SYNC_SHORT = 6;             // short sync length

    // A character ready to be loaded into the shifter.
    typedef struct packed {
        logic [SR_W-1:0]  bits;    // LSB goes out first
        logic [CNT_W-1:0] len;     // total bits including parity
        logic [CNT_W-1:0] ndata;   // leading bits that are data
        logic             crc;     // data bits are fed to the CRC
    } char_frame_t;

    // Number of data bits for a length code; code 0 decodes a marker prefix.
    function automatic logic [CNT_W-1:0] data_bits(input logic [1:0] code,
                                                   input logic [DATA_W-1:0] b);
        logic [CNT_W-1:0] n;
        case (code)
            2'd1:    n = CNT_W'(6);
            2'd2:    n = CNT_W'(7);
            2'd3:    n = CNT_W'(8);
            default: begin
                if (!b[7])      n = CNT_W'(5);
                else if (!b[6]) n = CNT_W'(4);
                else if (!b[5]) n = CNT_W'(3);
                else if (!b[4]) n = CNT_W'(2);
                else            n = CNT_W'(1);
            end
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sct_baud_gen.sv
// Bit-rate divider: raises tick for one clock out of every DIV clocks.
// Assumes DIV >= 1; DIV = 1 gives a tick on every cycle.
module sct_baud_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV == 1) begin : g_every
            // Every cycle is a bit period.
            assign tick = rst_n;
        end else begin : g_count
            localparam int DW = $clog2(DIV);
            logic [DW-1:0] cnt;

            // Free-running modulo-DIV counter.
            always_ff @(posedge clk) begin
                if (!rst_n)                     cnt <= '0;
                else if (cnt == DW'(DIV - 1))   cnt <= '0;
                else                            cnt <= cnt + DW'(1);
            end

            assign tick = (cnt == DW'(DIV - 1));

            a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/sct_framer.sv
// Framer: builds the next character for the shifter, either the buffered
// byte (masked, with optional parity) or the sync fill. Purely combinational.
module sct_framer
    import sct_pkg::*;
(
    input  logic              use_data,
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              crc_inc,
    input  logic              sync16,
    input  logic              sync8,
    input  logic [SYNC_W-1:0] sync_lo,
    input  logic [SYNC_W-1:0] sync_hi,
    output char_frame_t       frame
);

    logic [CNT_W-1:0]  n;
    logic [DATA_W-1:0] masked;
    logic              par_bit;
    char_frame_t       data_fr;
    char_frame_t       sync_fr;

    assign n = data_bits(len_code, data);

    // Keep only the bits below the decoded length.
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_mask
            assign masked[gi] = data[gi] & (CNT_W'(gi) < n);
        end
    endgenerate

    // Parity bit: XOR of data, inverted for odd parity.
    assign par_bit = (^masked) ^ ~par_even;

    // Data character with parity placed just above the data bits.
    always_comb begin
        data_fr.bits  = SR_W'(masked) | (par_en ? (SR_W'(par_bit) << n) : '0);
        data_fr.len   = n + CNT_W'(par_en);
        data_fr.ndata = n;
        data_fr.crc   = crc_inc;
    end

    // Sync fill of the selected length, right-justified.
    always_comb begin
        sync_fr.ndata = '0;
        sync_fr.crc   = 1'b0;
        if (sync16) begin
            sync_fr.bits = {sync_hi, sync_lo};
            sync_fr.len  = CNT_W'(SR_W);
        end else if (sync8) begin
            sync_fr.bits = SR_W'(sync_lo);
            sync_fr.len  = CNT_W'(SYNC_W);
        end else begin
            sync_fr.bits = SR_W'(sync_lo[SYNC_SHORT-1:0]);
            sync_fr.len  = CNT_W'(SYNC_SHORT);
        end
    end

    // Pick data over sync whenever a byte is waiting.
    assign frame = use_data ? data_fr : sync_fr;

endmodule

// File: rtl/sct_shifter.sv
// Shifter: sends one frame LSB first, one bit per tick, and loads the next
// frame on the tick after the last bit. Assumes every frame has len >= 1.
module sct_shifter
    import sct_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  char_frame_t nxt,
    output logic        load,
    output logic        txd,
    output logic        shift_en,
    output logic        crc_feed
);

    logic [SR_W-1:0]  sreg;
    logic [CNT_W-1:0] left;     // bits of the current frame still on the line, incl. current
    logic [CNT_W-1:0] dleft;    // data bits still on the line, incl. current
    logic             crc_q;

    assign load = tick && (left <= CNT_W'(1));

    // Bit sequencing: load a frame or shift out the next bit on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg     <= '0;
            left     <= '0;
            dleft    <= '0;
            crc_q    <= 1'b0;
            txd      <= 1'b1;
            shift_en <= 1'b0;
            crc_feed <= 1'b0;
        end else begin
            shift_en <= tick;
            if (load) begin
                txd      <= nxt.bits[0];
                sreg     <= nxt.bits >> 1;
                left     <= nxt.len;
                dleft    <= nxt.ndata;
                crc_q    <= nxt.crc;
                crc_feed <= nxt.crc && (nxt.ndata != '0);
            end else if (tick) begin
                txd      <= sreg[0];
                sreg     <= sreg >> 1;
                left     <= left - CNT_W'(1);
                if (dleft != '0) dleft <= dleft - CNT_W'(1);
                crc_feed <= crc_q && (dleft > CNT_W'(1));
            end else begin
                crc_feed <= 1'b0;
            end
        end
    end

    a_r2_txd_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> shift_en);
    a_r8_feed_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
        crc_feed |-> shift_en);
    a_r8_feed_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        crc_feed |-> (dleft != '0));
    a_r4_left_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        left <= CNT_W'(SR_W));

endmodule

// File: rtl/sync_char_tx.sv
// Top: single-entry holding buffer in front of the framer and shifter.
// A waiting byte is taken at a character boundary; otherwise sync is sent.
// Assumes configuration inputs are synchronous to clk.
module sync_char_tx
    import sct_pkg::*;
#(
    parameter int BAUD_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sync16,
    input  logic              cfg_sync8,
    input  logic [SYNC_W-1:0] sync_lo,
    input  logic [SYNC_W-1:0] sync_hi,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_crc_inc,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              shift_en,
    output logic              buf_empty,
    output logic              crc_feed
);

    logic              tick;
    logic              load;
    logic [DATA_W-1:0] hold;
    char_frame_t       nxt;

    sct_baud_gen #(.DIV(BAUD_DIV)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sct_framer u_framer (
        .use_data (!buf_empty),
        .data     (hold),
        .len_code (cfg_len),
        .par_en   (cfg_par_en),
        .par_even (cfg_par_even),
        .crc_inc  (cfg_crc_inc),
        .sync16   (cfg_sync16),
        .sync8    (cfg_sync8),
        .sync_lo  (sync_lo),
        .sync_hi  (sync_hi),
        .frame    (nxt)
    );

    sct_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .nxt      (nxt),
        .load     (load),
        .txd      (txd),
        .shift_en (shift_en),
        .crc_feed (crc_feed)
    );

    // Holding buffer: a write stores the byte; a load consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            buf_empty <= 1'b1;
        end else if (wr_en) begin
            hold      <= wr_data;
            buf_empty <= 1'b0;
        end else if (load) begin
            buf_empty <= 1'b1;
        end
    end

    a_r10_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !buf_empty);
    a_r10_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !buf_empty && !wr_en) |=> buf_empty);
    a_r10_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_empty && !wr_en) |=> buf_empty);

endmodule

// File: tb/sync_char_tx_test.sv
module sync_char_tx_test;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sync16 = 1'b1, cfg_sync8 = 1'b1;
    logic [7:0] sync_lo = 8'h16, sync_hi = 8'hA5;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_crc_inc = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, shift_en, buf_empty, crc_feed;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;

    always #5 clk = ~clk;

    sync_char_tx #(.BAUD_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_sync16(cfg_sync16), .cfg_sync8(cfg_sync8),
        .sync_lo(sync_lo), .sync_hi(sync_hi), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_crc_inc(cfg_crc_inc),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .shift_en(shift_en),
        .buf_empty(buf_empty), .crc_feed(crc_feed)
    );

    // Inputs as the design saw them at the last rising edge.
    logic       s_rst, s_wr, s_s16, s_s8, s_pe, s_pev, s_crc;
    logic [7:0] s_wd, s_lo, s_hi;
    logic [1:0] s_len;
    always @(posedge clk) begin
        s_rst <= rst_n;  s_wr <= wr_en;  s_wd <= wr_data;
        s_s16 <= cfg_sync16; s_s8 <= cfg_sync8; s_lo <= sync_lo; s_hi <= sync_hi;
        s_len <= cfg_len; s_pe <= cfg_par_en; s_pev <= cfg_par_even; s_crc <= cfg_crc_inc;
    end

    // Reference stream for the character in flight.
    logic q_bit [0:15];
    logic q_crc [0:15];
    int   q_tag [0:15];
    int   q_len = 0, q_pos = 0;
    logic m_full = 1'b0;
    logic [7:0] m_byte = 8'h00;
    int   last_tick = -1;
    int   gap_checks = 0;
    logic prev_txd = 1'b1;

    function automatic string tag_name(input int t);
        case (t)
            0: return "R3/R4";
            1: return "R5/R4";
            2: return "R6/R4";
            default: return "R7/R4";
        endcase
    endfunction

    function automatic int bits_for(input logic [1:0] code, input logic [7:0] b);
        int k = 0;
        if (code == 2'd1) return 6;
        if (code == 2'd2) return 7;
        if (code == 2'd3) return 8;
        while (k < 4 && b[7-k]) k++;
        return 5 - k;
    endfunction

    // Build the expected next character from the sampled inputs.
    task automatic refill();
        q_pos = 0;
        if (m_full) begin
            int n = bits_for(s_len, m_byte);
            int ones = 0;
            for (int i = 0; i < n; i++) begin
                q_bit[i] = m_byte[i]; q_crc[i] = s_crc;
                q_tag[i] = (s_len == 2'd0) ? 2 : 1;
                ones += m_byte[i];
            end
            q_len = n;
            if (s_pe) begin
                q_bit[n] = s_pev ? logic'(ones % 2) : logic'((ones + 1) % 2);
                q_crc[n] = 1'b0; q_tag[n] = 3; q_len = n + 1;
            end
            m_full = 1'b0;
        end else begin
            logic [15:0] pat = {s_hi, s_lo};
            q_len = s_s16 ? 16 : (s_s8 ? 8 : 6);
            for (int i = 0; i < q_len; i++) begin
                q_bit[i] = pat[i]; q_crc[i] = 1'b0; q_tag[i] = 0;
            end
        end
    endtask

    task automatic report(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycle, act, exp);
        end
    endtask

    // Monitor: checks outputs against the reference between clock edges.
    always @(negedge clk) begin
        cycle++;
        if (!s_rst) begin
            q_len = 0; q_pos = 0; m_full = 1'b0; last_tick = -1; prev_txd = txd;
        end else begin
            if (!shift_en && txd != prev_txd) report("R2 txd moved without shift_en", 1, 0);
            if (shift_en) begin
                if (last_tick >= 0 && gap_checks < 40) begin
                    report("R2 bit period", cycle - last_tick, DIV);
                    gap_checks++;
                end
                last_tick = cycle;
                if (q_pos >= q_len) refill();
                report(tag_name(q_tag[q_pos]), int'(txd), int'(q_bit[q_pos]));
                report("R8/R9 crc_feed", int'(crc_feed), int'(q_crc[q_pos]));
                q_pos++;
            end else if (crc_feed) begin
                report("R8 crc_feed without shift_en", 1, 0);
            end
            if (s_wr) begin m_byte = s_wd; m_full = 1'b1; end
            if (shift_en || s_wr) report("R10 buf_empty", int'(buf_empty), int'(!m_full));
            prev_txd = txd;
        end
        if (cycle > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycle);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        while (!buf_empty) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [7:0] five_pat [0:4];

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        five_pat[0] = 8'hF1; five_pat[1] = 8'hE2; five_pat[2] = 8'hC5;
        five_pat[3] = 8'h8A; five_pat[4] = 8'h15;

        // R1: reset state
        repeat (3) @(negedge clk);
        report("R1 txd", int'(txd), 1);
        report("R1 buf_empty", int'(buf_empty), 1);
        report("R1 shift_en", int'(shift_en), 0);
        report("R1 crc_feed", int'(crc_feed), 0);
        rst_n = 1'b1;
        @(negedge clk);
        report("R1 txd after release", int'(txd), 1);

        // R3: sync fill in each length
        idle(DIV * 40);
        cfg_sync16 = 1'b0; cfg_sync8 = 1'b1; sync_lo = 8'h3C; idle(DIV * 30);
        cfg_sync8 = 1'b0; sync_lo = 8'hE9; idle(DIV * 30);
        cfg_sync16 = 1'b1; sync_lo = 8'h16; sync_hi = 8'h96;

        // R5: each length with upper bits set
        for (int c = 0; c < 4; c++) begin
            cfg_len = 2'(c);
            write_byte(8'hFF - 8'(c * 17)); wait_empty();
        end
        // R6: marker formats, R7 parity both polarities
        cfg_len = 2'd0;
        for (int p = 0; p < 5; p++) begin
            cfg_par_en = p[0]; cfg_par_even = p[1];
            write_byte(five_pat[p]); wait_empty();
        end
        cfg_len = 2'd3; cfg_par_en = 1'b1;
        for (int p = 0; p < 4; p++) begin
            cfg_par_even = p[0];
            write_byte(8'(p * 8'h35)); wait_empty();
        end

        // R9: flag captured at load, then changed while bits still pending
        cfg_par_en = 1'b0; cfg_crc_inc = 1'b1;
        write_byte(8'h5A); wait_empty();
        @(negedge clk); cfg_crc_inc = 1'b0;
        write_byte(8'hC3); wait_empty();
        @(negedge clk); cfg_crc_inc = 1'b1;
        idle(DIV * 20);

        // R10: continuous writes so every load edge meets a write
        @(negedge clk); wr_en = 1'b1;
        for (int i = 0; i < 300; i++) begin
            wr_data = 8'($urandom);
            if (i % 37 == 0) cfg_crc_inc = ~cfg_crc_inc;
            @(negedge clk);
        end
        wr_en = 1'b0;
        idle(DIV * 20);

        // Random mix of settings, gaps and bytes
        for (int i = 0; i < 250; i++) begin
            @(negedge clk);
            cfg_len      = 2'($urandom_range(0, 3));
            cfg_par_en   = 1'($urandom);
            cfg_par_even = 1'($urandom);
            cfg_crc_inc  = 1'($urandom);
            cfg_sync16   = 1'($urandom);
            cfg_sync8    = 1'($urandom);
            if ($urandom_range(0, 7) == 0) begin
                sync_lo = 8'($urandom); sync_hi = 8'($urandom);
            end
            idle($urandom_range(0, 50));
            write_byte((cfg_len == 2'd0 && $urandom_range(0, 1) == 1)
                       ? (five_pat[$urandom_range(0, 4)] ^ 8'($urandom_range(0, 1)))
                       : 8'($urandom));
        end
        wait_empty();
        idle(DIV * 40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule